// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

This block watches the single tearing-effect line driven by a display panel and tells horizontal sync pulses from vertical sync pulses purely by how long each pulse lasts. A short pulse is a horizontal sync and a long pulse is a vertical sync. One tick is one cycle of `clk`. The horizontal threshold is given in ticks. The vertical threshold is given in units of eight ticks.

After each vertical sync the block counts horizontal syncs. Depending on the selected mode, it raises a one-cycle `match` strobe either on every vertical sync or when the line count reaches a programmed target line. A frame transfer engine uses that strobe to start writing at a safe point in the panel refresh.

The pin is asynchronous and passes through a two-flop synchronizer. The block has no streaming data path. All of its pins are plain control and status levels or strobes, with no back-pressure.

Top module: `te_pulse_detector`

## Requirements
- R1: `te_pin` is synchronized by two flops. The horizontal channel measures the level `te_pin ^ hs_invert` and the vertical channel measures `te_pin ^ vs_invert`, so a value of 1 in an invert input makes a low-going pulse the active one.
- R2: A vertical-channel pulse whose active width W (in clk cycles) satisfies W >= (vs_width_cfg+1)*8 produces exactly one `vsync_evt` strobe, two cycles after the synchronized level ends.
- R3: A horizontal-channel pulse with hs_width_cfg+1 <= W < (vs_width_cfg+1)*8 produces exactly one `hsync_evt` strobe and no `vsync_evt`.
- R4: A pulse with W < hs_width_cfg+1 produces no event and leaves `line_count` unchanged.
- R5: `hsync_evt` and `vsync_evt` are never high in the same cycle.
- R6: A `vsync_evt` sets `line_count` to 0 on the next cycle. Each later `hsync_evt` adds 1, and the count holds once it reaches 2^LINE_W-1.
- R7: In mode 3 (vertical only), `match` pulses on the cycle after each `vsync_evt` and never follows an `hsync_evt`.
- R8: In mode 2 (line match), `match` follows a `vsync_evt` when target_line is 0, and otherwise follows the `hsync_evt` that brings `line_count` from target_line-1 to target_line. Horizontal syncs seen since enable but before the first vertical sync are not counted and never match.
- R9: In modes 0 and 1, `match` stays low.
- R10: While `enable` is low there are no events and no match, `line_count` reads 0, and the wait for a first vertical sync starts over.
- R11: `match` is one cycle wide and always comes exactly one cycle after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| te_pin | input | 1 | Asynchronous tearing-effect line from the panel |
| enable | input | 1 | Gates all tearing logic |
| mode | input | 2 | 0/1 off, 2 line match, 3 vertical only |
| hs_invert | input | 1 | Invert pin level for horizontal measurement |
| vs_invert | input | 1 | Invert pin level for vertical measurement |
| hs_width_cfg | input | HS_W | Horizontal threshold in ticks minus one |
| vs_width_cfg | input | VS_W | Vertical threshold in 8-tick units minus one |
| target_line | input | LINE_W | Line number for mode 2 |
| hsync_evt | output | 1 | One-cycle strobe per classified horizontal sync |
| vsync_evt | output | 1 | One-cycle strobe per classified vertical sync |
| match | output | 1 | One-cycle strobe when the mode condition is met |
| line_count | output | LINE_W | Horizontal syncs counted since last vertical sync |

## Verification
The bench builds the block with VS_W=4 and LINE_W=4, and keeps HS_W=3. This caps the vertical threshold at 128 ticks, so every horizontal setting can be swept against several vertical settings with pulse widths on both sides of each threshold. It also makes the line counter saturate at 15, so every target line, including 0 and the saturating value, can be run through a full frame of line matching. Polarity inversion, each mode and the enable gate are each run under their own pulse patterns.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [1:0] {
    TE_OFF   = 2'd0,
    TE_RSVD  = 2'd1,
    TE_LINE  = 2'd2,
    TE_VONLY = 2'd3
  } te_mode_e;

  localparam int TE_SYNC_STAGES = 2;
  localparam int TE_CHANNELS    = 2;
  localparam int TE_CH_H        = 0;
  localparam int TE_CH_V        = 1;
endpackage

// File: rtl/te_pin_sync.sv
module te_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/te_width_meter.sv
module te_width_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  output logic             pulse_end,
  output logic [CNT_W-1:0] width
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (active) begin
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
    end
    else                     cnt_q <= '0;
  end

  // A pulse ends on the first inactive cycle after at least one active cycle.
  assign pulse_end = !active && (cnt_q != '0) && !clear;
  assign width     = cnt_q;
endmodule

// File: rtl/te_line_matcher.sv
module te_line_matcher
  import te_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  te_mode_e          mode,
  input  logic [LINE_W-1:0] target,
  input  logic              hs_evt,
  input  logic              vs_evt,
  output logic              match,
  output logic [LINE_W-1:0] line_count
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic              armed_q;
  logic [LINE_W-1:0] cnt_q;
  logic              match_q;
  logic [LINE_W-1:0] cnt_inc;
  logic              at_max;
  logic              hit_line;

  assign at_max   = (cnt_q == LINE_MAX);
  assign cnt_inc  = cnt_q + 1'b1;
  assign hit_line = armed_q && !at_max && (cnt_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (vs_evt) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        unique case (mode)
          TE_VONLY: match_q <= 1'b1;
          TE_LINE:  match_q <= (target == '0);
          default:  match_q <= 1'b0;
        endcase
      end else if (hs_evt && armed_q) begin
        if (!at_max) cnt_q <= cnt_inc;
        match_q <= (mode == TE_LINE) && hit_line;
      end
    end
  end

  assign match      = match_q;
  assign line_count = cnt_q;
endmodule

// File: rtl/te_pulse_detector.sv
module te_pulse_detector
  import te_pkg::*;
#(
  parameter int HS_W         = 3,
  parameter int VS_W         = 12,
  parameter int VS_UNIT_LOG2 = 3,
  parameter int LINE_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_pin,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              hs_invert,
  input  logic              vs_invert,
  input  logic [HS_W-1:0]   hs_width_cfg,
  input  logic [VS_W-1:0]   vs_width_cfg,
  input  logic [LINE_W-1:0] target_line,
  output logic              hsync_evt,
  output logic              vsync_evt,
  output logic              match,
  output logic [LINE_W-1:0] line_count
);
  localparam int CNT_W = VS_W + VS_UNIT_LOG2 + 1;

  logic                 pin_s;
  logic [TE_CHANNELS-1:0] ch_active;
  logic [TE_CHANNELS-1:0] ch_end;
  logic [CNT_W-1:0]     ch_width [TE_CHANNELS];
  logic [CNT_W-1:0]     hs_ticks;
  logic [CNT_W-1:0]     vs_ticks;
  logic                 hs_q, vs_q;

  te_pin_sync #(.STAGES(TE_SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (te_pin),
    .dout (pin_s)
  );

  assign ch_active[TE_CH_H] = pin_s ^ hs_invert;
  assign ch_active[TE_CH_V] = pin_s ^ vs_invert;

  for (genvar gi = 0; gi < TE_CHANNELS; gi++) begin : g_meter
    te_width_meter #(.CNT_W(CNT_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!enable),
      .active   (ch_active[gi]),
      .pulse_end(ch_end[gi]),
      .width    (ch_width[gi])
    );
  end

  assign hs_ticks = CNT_W'(hs_width_cfg) + 1'b1;
  assign vs_ticks = (CNT_W'(vs_width_cfg) + 1'b1) << VS_UNIT_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      vs_q <= enable && ch_end[TE_CH_V] && (ch_width[TE_CH_V] >= vs_ticks);
      hs_q <= enable && ch_end[TE_CH_H] && (ch_width[TE_CH_H] >= hs_ticks)
                     && (ch_width[TE_CH_H] < vs_ticks);
    end
  end

  assign hsync_evt = hs_q;
  assign vsync_evt = vs_q;

  te_line_matcher #(.LINE_W(LINE_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mode      (te_mode_e'(mode)),
    .target    (target_line),
    .hs_evt    (hs_q),
    .vs_evt    (vs_q),
    .match     (match),
    .line_count(line_count)
  );
endmodule

// File: rtl/te_pulse_detector_checker.sv
module te_pulse_detector_checker #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [1:0]        mode,
  input logic              hsync_evt,
  input logic              vsync_evt,
  input logic              match,
  input logic [LINE_W-1:0] line_count
);
  assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsync_evt && vsync_evt));

  assert_vs_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt |=> (line_count == '0));

  assert_vonly_vs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_evt && enable && mode == 2'd3) |=> match);

  assert_vonly_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_evt && mode == 2'd3) |=> !match);

  assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !match);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!match && !hsync_evt && !vsync_evt && line_count == '0));

  assert_match_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);

  assert_match_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(hsync_evt || vsync_evt));
endmodule

bind te_pulse_detector te_pulse_detector_checker #(.LINE_W(LINE_W)) u_te_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .mode      (mode),
  .hsync_evt (hsync_evt),
  .vsync_evt (vsync_evt),
  .match     (match),
  .line_count(line_count)
);

// File: tb/te_pulse_detector_bench.sv
`timescale 1ns/1ps
module te_pulse_detector_bench;
  localparam int HS_W = 3, VS_W = 4, LINE_W = 4;
  localparam int LMAX = (1 << LINE_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, te_pin = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic hs_invert = 1'b0, vs_invert = 1'b0;
  logic [HS_W-1:0] hs_cfg = '0;
  logic [VS_W-1:0] vs_cfg = '0;
  logic [LINE_W-1:0] target = '0;
  logic hsync_evt, vsync_evt, match;
  logic [LINE_W-1:0] line_count;

  int checks = 0, errors = 0;
  int hs_n = 0, vs_n = 0, m_n = 0, lat_err = 0;
  logic prev_evt = 1'b0, prev_m = 1'b0;
  logic inv = 1'b0;

  always #2.5 clk = ~clk;

  te_pulse_detector #(.HS_W(HS_W), .VS_W(VS_W), .VS_UNIT_LOG2(3), .LINE_W(LINE_W))
  u_te_pulse_detector (
    .clk(clk), .rst_n(rst_n), .te_pin(te_pin), .enable(enable), .mode(mode),
    .hs_invert(hs_invert), .vs_invert(vs_invert), .hs_width_cfg(hs_cfg),
    .vs_width_cfg(vs_cfg), .target_line(target), .hsync_evt(hsync_evt),
    .vsync_evt(vsync_evt), .match(match), .line_count(line_count));

  always @(posedge clk) begin
    if (rst_n) begin
      if (hsync_evt) hs_n++;
      if (vsync_evt) vs_n++;
      if (match) m_n++;
      if (match && !prev_evt) lat_err++;
      if (match && prev_m) lat_err++;
    end
    prev_evt <= hsync_evt | vsync_evt;
    prev_m   <= match;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int w);
    @(negedge clk); te_pin = ~inv;
    repeat (w) @(negedge clk);
    te_pin = inv;
    repeat (8) @(negedge clk);
  endtask

  task automatic reenable();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk); enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h0, v0, m0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hsync_evt && !vsync_evt && !match && line_count == 0, "R10 reset",
          int'(match), 0);

    // R10: disabled block is quiet
    hs_cfg = 3'd1; vs_cfg = 4'd0; mode = 2'd3;
    h0 = hs_n; v0 = vs_n; m0 = m_n;
    pulse(3); pulse(12);
    check(hs_n == h0 && vs_n == v0 && m_n == m0 && line_count == 0,
          "R10 disabled", hs_n + vs_n + m_n - h0 - v0 - m0, 0);

    // R2 R3 R4 sweep of widths around both thresholds
    enable = 1'b1; mode = 2'd0;
    for (int hf = 0; hf < 8; hf++) begin
      for (int vf = 0; vf < 3; vf++) begin
        hs_cfg = HS_W'(hf); vs_cfg = VS_W'(vf);
        for (int w = 1; w <= (vf + 1) * 8 + 2; w++) begin
          int eh, ev;
          ev = (w >= (vf + 1) * 8) ? 1 : 0;
          eh = (!ev && w >= hf + 1) ? 1 : 0;
          h0 = hs_n; v0 = vs_n;
          pulse(w);
          check(vs_n - v0 == ev, "R2 vsync width", vs_n - v0, ev);
          check(hs_n - h0 == eh, eh ? "R3 hsync width" : "R4 glitch", hs_n - h0, eh);
        end
      end
    end

    // R4: glitch leaves line count unchanged
    hs_cfg = 3'd3; vs_cfg = 4'd0; mode = 2'd2; target = 4'd15;
    reenable();
    pulse(10); pulse(5); pulse(5);
    pulse(2); pulse(1);
    check(line_count == 2, "R4 line unchanged", int'(line_count), 2);

    // R1: inverted polarity, low-going pulses
    hs_invert = 1'b1; vs_invert = 1'b1; inv = 1'b1; te_pin = 1'b1;
    hs_cfg = 3'd1; vs_cfg = 4'd0;
    reenable();
    h0 = hs_n; v0 = vs_n;
    pulse(3); pulse(10); pulse(3);
    check(hs_n - h0 == 2 && vs_n - v0 == 1, "R1 inverted", hs_n - h0, 2);
    check(line_count == 1, "R1 inverted count", int'(line_count), 1);
    hs_invert = 1'b0; vs_invert = 1'b0; inv = 1'b0; te_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R8 R6: every target line, with saturation
    mode = 2'd2;
    for (int t = 0; t <= LMAX; t++) begin
      target = LINE_W'(t);
      reenable();
      m0 = m_n;
      pulse(3); pulse(3);
      check(m_n == m0 && line_count == 0, "R8 before first vsync", m_n - m0, 0);
      pulse(10);
      check(line_count == 0, "R6 vsync clears", int'(line_count), 0);
      for (int k = 1; k <= LMAX + 2; k++) begin
        pulse(3);
        if (k == 1 || k == LMAX + 2)
          check(int'(line_count) == (k > LMAX ? LMAX : k), "R6 count",
                int'(line_count), (k > LMAX ? LMAX : k));
      end
      check(m_n - m0 == 1, "R8 target match", m_n - m0, 1);
    end

    // R7: vertical-only mode
    mode = 2'd3; reenable();
    m0 = m_n;
    pulse(10); pulse(3); pulse(3); pulse(10); pulse(3); pulse(10);
    check(m_n - m0 == 3, "R7 vertical only", m_n - m0, 3);

    // R9: modes 0 and 1
    for (int md = 0; md < 2; md++) begin
      mode = 2'(md); target = 4'd0; reenable();
      m0 = m_n;
      pulse(10); pulse(3); pulse(10);
      check(m_n == m0, "R9 mode off", m_n - m0, 0);
    end

    // R5 R11: event exclusivity and match timing observed across the run
    check(lat_err == 0, "R11 match timing", lat_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule